// File: doc/BRIEF.md
# Serial-wire debug bring-up sequencer

This controller takes a serial-wire debug target from an unknown line state to a memory access port that is ready for word transfers. After a start pulse it hands a fixed run of raw bit chunks to the wire engine below it: a line reset, the protocol switch code and a second reset, then idle. It then issues a fixed recipe of register requests through the same engine. The recipe checks the target's identity and raises and polls the power handshake. It then pulses the debug reset handshake, checks the type of the default access port, and programs that port's control word.

Each poll has a bound: `retry_max_i` gives the number of extra reads allowed. The block ends in a held done state, or in a held error state with a code that names the failing step. Wire timing, framing, parity and acknowledge decoding belong to the engine. The engine reports each register request as either completed (`reg_ok_i`=1, with read data) or failed.

Top module: `dbg_bringup_seq`

## Requirements
- R1: After reset no request is raised and done_o and err_o are low until a start pulse arrives.
- R2: A run first sends seven raw chunks in this order, each least significant bit first: 32 ones, 32 ones, the 16-bit value 0xE79E, 32 ones, 32 ones, 32 zeros, 32 zeros. Each chunk gives its bit count on raw_len_o. No register request overlaps a raw request.
- R3: The first register request is a debug-port read at address field 0. The run fails with code 2 unless the read data ANDed with 0x0FF00001 equals 0x0BA00001.
- R4: The sequencer writes 0x50000000 (power requests at bits 30 and 28) to the debug-port control word at address field 1. It then reads that word until bits 31 and 29 are both set.
- R5: The sequencer then writes 0x54000000, which adds the reset request at bit 26. It reads the control word until bits 31, 29 and 27 are all set.
- R6: The sequencer then writes 0x50000000 once, which drops the reset request.
- R7: Access-port requests are preceded by a bank-select write to debug-port address field 2, and only when the cached bank differs. The value is 0x000000F0 before the identification read and 0x00000000 before the control-word write. The cache is set to all ones at every start.
- R8: The access-port identification register is read twice at address field 3 because access-port reads are posted. Only the second result is checked, and the run fails with code 5 unless its low 4 bits equal 1.
- R9: The final request writes 0x00000012 to access-port address field 0: increment-single in bits [5:4] and word size in bits [2:0]. After that done_o rises.
- R10: A poll that has made retry_max_i+1 reads without a match ends the run with code 3 (power) or code 4 (reset).
- R11: A request answered with reg_ok_i=0 ends the run at once with code 1, and no further request is issued.
- R12: A request stays raised until it is acknowledged. done_o and err_o are never both high, and both hold until the next start. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a bring-up run when idle, done or in error |
| retry_max_i | input | RETRY_W | Extra reads allowed per poll |
| raw_req_o | output | 1 | Raw chunk request |
| raw_data_o | output | 32 | Raw chunk bits, sent LSB first |
| raw_len_o | output | 6 | Number of bits in the chunk |
| raw_ack_i | input | 1 | Engine finished the raw chunk |
| reg_req_o | output | 1 | Register request |
| reg_ap_o | output | 1 | 1 for access port, 0 for debug port |
| reg_rd_o | output | 1 | 1 for read, 0 for write |
| reg_addr_o | output | 2 | Register address field (address bits 3:2) |
| reg_wdata_o | output | 32 | Write data, zero for reads |
| reg_ack_i | input | 1 | Engine finished the register request |
| reg_ok_i | input | 1 | Request completed without failure |
| reg_rdata_i | input | 32 | Read data, valid with reg_ack_i |
| done_o | output | 1 | Bring-up completed |
| err_o | output | 1 | Bring-up failed |
| err_code_o | output | 3 | Failure code: 1 link, 2 identity, 3 power timeout, 4 reset timeout, 5 port type |

## Verification
The bench builds the block with RETRY_W=8 and sweeps retry_max_i over 0 to 3. A target model delays each acknowledge by 0 to 4 extra reads. Every split between success and each timeout code is reached, including the case where the acknowledge arrives on the last permitted read. Runs are started back to back without a reset, which shows that the bank cache is invalidated at each start. The model answers the first posted port read with garbage, so a design that checked that first result would fail.

// File: rtl/dbg_bringup_pkg.sv
package dbg_bringup_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 6;
  localparam int CHUNKS  = 7;
  localparam int CHUNK_W = $clog2(CHUNKS);
  localparam int CODE_W  = 3;

  localparam logic [CODE_W-1:0] ERR_NONE  = 3'd0;
  localparam logic [CODE_W-1:0] ERR_LINK  = 3'd1;
  localparam logic [CODE_W-1:0] ERR_ID    = 3'd2;
  localparam logic [CODE_W-1:0] ERR_PWR   = 3'd3;
  localparam logic [CODE_W-1:0] ERR_RST   = 3'd4;
  localparam logic [CODE_W-1:0] ERR_APTYP = 3'd5;

  localparam logic [1:0] DP_ID   = 2'd0;
  localparam logic [1:0] DP_CTRL = 2'd1;
  localparam logic [1:0] DP_BANK = 2'd2;
  localparam logic [1:0] AP_CW   = 2'd0;
  localparam logic [1:0] AP_IDR  = 2'd3;

  localparam logic [WORD_W-1:0] PWR_REQ   = 32'h5000_0000;
  localparam logic [WORD_W-1:0] PWR_ACK   = 32'hA000_0000;
  localparam logic [WORD_W-1:0] RST_REQ   = 32'h0400_0000;
  localparam logic [WORD_W-1:0] RST_ACK   = 32'h0800_0000;
  localparam logic [WORD_W-1:0] ID_MASK   = 32'h0FF0_0001;
  localparam logic [WORD_W-1:0] ID_MATCH  = 32'h0BA0_0001;
  localparam logic [WORD_W-1:0] BANK_IDR  = 32'h0000_00F0;
  localparam logic [WORD_W-1:0] BANK_CW   = 32'h0000_0000;
  localparam logic [WORD_W-1:0] CW_INIT   = 32'h0000_0012;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RAW, ST_ID, ST_PWR_WR, ST_PWR_POLL, ST_RST_WR, ST_RST_POLL,
    ST_CLR_WR, ST_SEL_IDR, ST_IDR_0, ST_IDR_1, ST_SEL_CW, ST_CW_WR,
    ST_DONE, ST_ERR
  } step_e;
endpackage

// File: rtl/bringup_raw_rom.sv
module bringup_raw_rom
  import dbg_bringup_pkg::*;
(
  input  logic [CHUNK_W-1:0] idx_i,
  output logic [WORD_W-1:0]  data_o,
  output logic [LEN_W-1:0]   len_o
);
  // order is behaviour: reset, switch code, reset, idle
  always_comb begin
    len_o = LEN_W'(32);
    case (idx_i)
      3'd0, 3'd1, 3'd3, 3'd4: data_o = '1;
      3'd2: begin
        data_o = 32'h0000_E79E;
        len_o  = LEN_W'(16);
      end
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/bringup_retry_ctr.sv
module bringup_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] max_i,
  output logic         spent_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q >= max_i);
endmodule

// File: rtl/dbg_bringup_seq.sv
module dbg_bringup_seq
  import dbg_bringup_pkg::*;
#(
  parameter int RETRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  output logic               raw_req_o,
  output logic [31:0]        raw_data_o,
  output logic [5:0]         raw_len_o,
  input  logic               raw_ack_i,
  output logic               reg_req_o,
  output logic               reg_ap_o,
  output logic               reg_rd_o,
  output logic [1:0]         reg_addr_o,
  output logic [31:0]        reg_wdata_o,
  input  logic               reg_ack_i,
  input  logic               reg_ok_i,
  input  logic [31:0]        reg_rdata_i,
  output logic               done_o,
  output logic               err_o,
  output logic [2:0]         err_code_o
);
  localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(CHUNKS - 1);

  step_e               st_q;
  logic                req_q;
  logic [CHUNK_W-1:0]  chunk_q;
  logic [WORD_W-1:0]   bank_q;
  logic [CODE_W-1:0]   code_q;

  logic is_txn, d_ap, d_rd, bank_hit, can_start, fin, pwr_ok, rst_ok;
  logic poll_miss, spent;
  logic [1:0]        d_a;
  logic [WORD_W-1:0] d_wd;

  bringup_raw_rom u_rom (
    .idx_i  (chunk_q),
    .data_o (raw_data_o),
    .len_o  (raw_len_o)
  );

  always_comb begin
    is_txn = 1'b1; d_ap = 1'b0; d_rd = 1'b0; d_a = DP_ID; d_wd = '0;
    case (st_q)
      ST_ID:       d_rd = 1'b1;
      ST_PWR_WR:   begin d_a = DP_CTRL; d_wd = PWR_REQ; end
      ST_PWR_POLL: begin d_a = DP_CTRL; d_rd = 1'b1; end
      ST_RST_WR:   begin d_a = DP_CTRL; d_wd = PWR_REQ | RST_REQ; end
      ST_RST_POLL: begin d_a = DP_CTRL; d_rd = 1'b1; end
      ST_CLR_WR:   begin d_a = DP_CTRL; d_wd = PWR_REQ; end
      ST_SEL_IDR:  begin d_a = DP_BANK; d_wd = BANK_IDR; end
      ST_IDR_0,
      ST_IDR_1:    begin d_ap = 1'b1; d_rd = 1'b1; d_a = AP_IDR; end
      ST_SEL_CW:   begin d_a = DP_BANK; d_wd = BANK_CW; end
      ST_CW_WR:    begin d_ap = 1'b1; d_a = AP_CW; d_wd = CW_INIT; end
      default:     is_txn = 1'b0;
    endcase
  end

  assign bank_hit  = (st_q == ST_SEL_IDR || st_q == ST_SEL_CW) && (bank_q == d_wd);
  assign can_start = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);
  assign fin       = is_txn && req_q && reg_ack_i;
  assign pwr_ok    = (reg_rdata_i & PWR_ACK) == PWR_ACK;
  assign rst_ok    = (reg_rdata_i & (PWR_ACK | RST_ACK)) == (PWR_ACK | RST_ACK);
  assign poll_miss = fin && reg_ok_i &&
                     ((st_q == ST_PWR_POLL && !pwr_ok) || (st_q == ST_RST_POLL && !rst_ok));

  bringup_retry_ctr #(.W(RETRY_W)) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q == ST_PWR_WR || st_q == ST_RST_WR),
    .inc_i   (poll_miss && !spent),
    .max_i   (retry_max_i),
    .spent_o (spent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; req_q <= 1'b0; chunk_q <= '0; bank_q <= '1; code_q <= ERR_NONE;
    end else if (start_i && can_start) begin
      st_q <= ST_RAW; req_q <= 1'b0; chunk_q <= '0; bank_q <= '1; code_q <= ERR_NONE;
    end else if (st_q == ST_RAW) begin
      if (!req_q) req_q <= 1'b1;
      else if (raw_ack_i) begin
        req_q <= 1'b0;
        if (chunk_q == LAST_CHUNK) st_q <= ST_ID;
        else chunk_q <= chunk_q + 1'b1;
      end
    end else if (bank_hit) begin
      st_q <= (st_q == ST_SEL_IDR) ? ST_IDR_0 : ST_CW_WR;
    end else if (is_txn && !req_q) begin
      req_q <= 1'b1;
    end else if (fin) begin
      req_q <= 1'b0;
      if (!reg_ok_i) begin
        st_q <= ST_ERR; code_q <= ERR_LINK;
      end else begin
        case (st_q)
          ST_ID: if ((reg_rdata_i & ID_MASK) == ID_MATCH) st_q <= ST_PWR_WR;
                 else begin st_q <= ST_ERR; code_q <= ERR_ID; end
          ST_PWR_WR: st_q <= ST_PWR_POLL;
          ST_PWR_POLL: if (pwr_ok) st_q <= ST_RST_WR;
                       else if (spent) begin st_q <= ST_ERR; code_q <= ERR_PWR; end
          ST_RST_WR: st_q <= ST_RST_POLL;
          ST_RST_POLL: if (rst_ok) st_q <= ST_CLR_WR;
                       else if (spent) begin st_q <= ST_ERR; code_q <= ERR_RST; end
          ST_CLR_WR: st_q <= ST_SEL_IDR;
          ST_SEL_IDR: begin bank_q <= BANK_IDR; st_q <= ST_IDR_0; end
          ST_IDR_0: st_q <= ST_IDR_1;
          ST_IDR_1: if (reg_rdata_i[3:0] == 4'd1) st_q <= ST_SEL_CW;
                    else begin st_q <= ST_ERR; code_q <= ERR_APTYP; end
          ST_SEL_CW: begin bank_q <= BANK_CW; st_q <= ST_CW_WR; end
          ST_CW_WR: st_q <= ST_DONE;
          default: st_q <= ST_ERR;
        endcase
      end
    end
  end

  assign raw_req_o   = req_q && (st_q == ST_RAW);
  assign reg_req_o   = req_q && is_txn;
  assign reg_ap_o    = d_ap;
  assign reg_rd_o    = d_rd;
  assign reg_addr_o  = d_a;
  assign reg_wdata_o = d_wd;
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = (st_q == ST_ERR);
  assign err_code_o  = code_q;

  assert_one_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raw_req_o && reg_req_o));
  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i && !start_i |=> reg_req_o);
  assert_raw_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_req_o && !raw_ack_i && !start_i |=> raw_req_o);
  assert_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  assert_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != ERR_NONE);
  assert_clean_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> err_code_o == ERR_NONE);
  assert_bank_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ap_o |-> bank_q != '1);
  assert_link_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i && !reg_ok_i && !start_i |=> err_o);
  assert_poll_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_miss && spent && !start_i |=> err_o);
endmodule

// File: tb/dbg_bringup_seq_bench.sv
module dbg_bringup_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [7:0] rmax = '0;
  logic raw_req, raw_ack, reg_req, reg_ap, reg_rd, reg_ack, reg_ok, done, err;
  logic [31:0] raw_data, reg_wdata, reg_rdata, rdata_c;
  logic [5:0] raw_len;
  logic [1:0] reg_addr;
  logic [2:0] err_code;

  dbg_bringup_seq #(.RETRY_W(8)) u_dbg_bringup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retry_max_i(rmax),
    .raw_req_o(raw_req), .raw_data_o(raw_data), .raw_len_o(raw_len), .raw_ack_i(raw_ack),
    .reg_req_o(reg_req), .reg_ap_o(reg_ap), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_ack_i(reg_ack), .reg_ok_i(reg_ok), .reg_rdata_i(reg_rdata),
    .done_o(done), .err_o(err), .err_code_o(err_code));

  int checks = 0, fails = 0;
  int cfg_pd, cfg_rd, cfg_fail;
  logic [31:0] cfg_id, cfg_idr;
  logic clr = 1'b0;

  int raw_n, txn_n, poll_n, ap_n;
  logic [31:0] last_ctrl;
  logic [31:0] raw_d [64];
  logic [5:0]  raw_l [64];
  logic [35:0] txn   [64];
  logic [35:0] exp_t [64];

  always_comb begin
    rdata_c = 32'h0;
    if (reg_ap) rdata_c = (ap_n == 0) ? 32'hDEAD_BEEF : cfg_idr;
    else if (reg_addr == 2'd0) rdata_c = cfg_id;
    else if (reg_addr == 2'd1) begin
      if (last_ctrl[26]) rdata_c = 32'hA000_0000 | ((poll_n >= cfg_rd) ? 32'h0800_0000 : 32'h0);
      else               rdata_c = (poll_n >= cfg_pd) ? 32'hA000_0000 : 32'h0;
    end
  end

  // target model behind the wire engine
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      raw_ack <= 1'b0; reg_ack <= 1'b0; reg_ok <= 1'b0; reg_rdata <= '0;
      raw_n <= 0; txn_n <= 0; poll_n <= 0; ap_n <= 0; last_ctrl <= '0;
    end else begin
      raw_ack <= 1'b0; reg_ack <= 1'b0;
      if (raw_req && !raw_ack) begin
        raw_ack <= 1'b1;
        if (raw_n < 64) begin raw_d[raw_n] <= raw_data; raw_l[raw_n] <= raw_len; end
        raw_n <= raw_n + 1;
      end
      if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        reg_ok <= (txn_n != cfg_fail);
        reg_rdata <= rdata_c;
        if (txn_n < 64) txn[txn_n] <= {reg_ap, reg_rd, reg_addr, reg_wdata};
        txn_n <= txn_n + 1;
        if (reg_ap && reg_rd) ap_n <= ap_n + 1;
        if (!reg_ap && reg_addr == 2'd1) begin
          if (reg_rd) poll_n <= poll_n + 1;
          else begin last_ctrl <= reg_wdata; poll_n <= 0; end
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pk(input bit ap, input bit rd, input logic [1:0] a, input logic [31:0] wd);
    return {ap, rd, a, wd};
  endfunction

  task automatic run(input int pd, input int rd, input int rm, input logic [31:0] id,
                     input logic [31:0] idr, input int fail_at, input bit poke,
                     output bit fin_done, output logic [2:0] code);
    @(negedge clk);
    cfg_pd = pd; cfg_rd = rd; cfg_id = id; cfg_idr = idr; cfg_fail = fail_at;
    rmax = 8'(rm);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (poke && i == 40) start = 1'b1;
      else start = 1'b0;
      if (done || err) break;
      @(negedge clk);
    end
    start = 1'b0;
    fin_done = done;
    code = err_code;
  endtask

  bit d;
  logic [2:0] c;
  int n;

  initial begin
    cfg_pd = 0; cfg_rd = 0; cfg_fail = -1; cfg_id = 32'h2BA0_1477; cfg_idr = 32'h2477_0011;
    repeat (3) @(negedge clk);
    chk(!done && !err && !raw_req && !reg_req, "R1 reset state", {done, err, raw_req, reg_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !err && !raw_req && !reg_req, "R1 idle without start", {done, err, raw_req, reg_req}, 0);

    // sweep of poll delays against retry limit
    for (int rm = 0; rm < 4; rm++)
      for (int pd = 0; pd < 5; pd++)
        for (int rd = 0; rd < 5; rd++) begin
          bit ok_exp;
          logic [2:0] code_exp;
          ok_exp = (pd <= rm) && (rd <= rm);
          code_exp = (pd > rm) ? 3'd3 : (rd > rm) ? 3'd4 : 3'd0;
          run(pd, rd, rm, 32'h2BA0_1477, 32'h2477_0011, -1, (pd == 2 && rd == 1), d, c);
          chk(d == ok_exp && err == !ok_exp, "R10 outcome", {d, err}, {ok_exp, !ok_exp});
          chk(c == code_exp, "R10 error code", c, code_exp);
          chk(raw_n == 7, "R2 chunk count (R12 start ignored)", raw_n, 7);
          for (int k = 0; k < 7; k++) begin
            logic [31:0] ed;
            logic [5:0] el;
            ed = (k == 2) ? 32'h0000_E79E : (k >= 5) ? 32'h0 : 32'hFFFF_FFFF;
            el = (k == 2) ? 6'd16 : 6'd32;
            chk(raw_d[k] == ed && raw_l[k] == el, "R2 chunk content", {raw_d[k], raw_l[k]}, {ed, el});
          end
          n = 0;
          exp_t[n++] = pk(0, 1, 0, 0);
          exp_t[n++] = pk(0, 0, 1, 32'h5000_0000);
          for (int k = 0; k <= ((pd <= rm) ? pd : rm); k++) exp_t[n++] = pk(0, 1, 1, 0);
          if (pd <= rm) begin
            exp_t[n++] = pk(0, 0, 1, 32'h5400_0000);
            for (int k = 0; k <= ((rd <= rm) ? rd : rm); k++) exp_t[n++] = pk(0, 1, 1, 0);
            if (rd <= rm) begin
              exp_t[n++] = pk(0, 0, 1, 32'h5000_0000);
              exp_t[n++] = pk(0, 0, 2, 32'hF0);
              exp_t[n++] = pk(1, 1, 3, 0);
              exp_t[n++] = pk(1, 1, 3, 0);
              exp_t[n++] = pk(0, 0, 2, 32'h0);
              exp_t[n++] = pk(1, 0, 0, 32'h12);
            end
          end
          chk(txn_n == n, "R4 R5 R10 request count", txn_n, n);
          for (int k = 0; k < n && k < txn_n; k++)
            chk(txn[k] == exp_t[k],
                (k < 2) ? "R3 R4 request" : (ok_exp && k >= n - 6) ? "R6 R7 R8 R9 request" : "R5 request",
                txn[k], exp_t[k]);
          repeat (3) @(negedge clk);
          chk(done == d && err == !d, "R12 result held", {done, err}, {d, !d});
        end

    // identity mask
    run(0, 0, 0, 32'h4BA0_0477, 32'h2477_0011, -1, 0, d, c);
    chk(d && c == 0, "R3 identity accepted", {d, c}, {1'b1, 3'd0});
    run(0, 0, 0, 32'h0BB0_0001, 32'h2477_0011, -1, 0, d, c);
    chk(!d && c == 3'd2 && txn_n == 1, "R3 identity part rejected", {d, c, 8'(txn_n)}, {1'b0, 3'd2, 8'd1});
    run(0, 0, 0, 32'h0BA0_0000, 32'h2477_0011, -1, 0, d, c);
    chk(!d && c == 3'd2, "R3 identity bit0 rejected", {d, c}, {1'b0, 3'd2});

    // port type on second posted read
    run(0, 0, 2, 32'h2BA0_1477, 32'h2477_0012, -1, 0, d, c);
    chk(!d && c == 3'd5 && txn_n == 9, "R8 port type rejected", {d, c, 8'(txn_n)}, {1'b0, 3'd5, 8'd9});
    run(0, 0, 2, 32'h2BA0_1477, 32'h0000_00F1, -1, 0, d, c);
    chk(d && txn_n == 11, "R8 port type accepted", {d, 8'(txn_n)}, {1'b1, 8'd11});

    // link failure at each request position
    for (int f = 0; f < 11; f++) begin
      run(0, 0, 0, 32'h2BA0_1477, 32'h2477_0011, f, 0, d, c);
      chk(!d && c == 3'd1, "R11 link error code", {d, c}, {1'b0, 3'd1});
      chk(txn_n == f + 1, "R11 no request after failure", txn_n, f + 1);
    end

    // reset returns to idle
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!done && !err && err_code == 0, "R1 reset clears result", {done, err, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule